// File: doc/BRIEF.md
# Predicated Vector Shift Unit

This block shifts every element of a packed vector by its own amount. The amount for each element comes from the matching element of a second vector. The operation is one of three: arithmetic right, logical right or left. A 32-bit instruction word selects the operation, the element size and whether the roles of the two vectors are swapped. A governing predicate picks which elements take the new value. Elements that are not selected keep the value they had in the destination vector.

The caller supplies the instruction word, the destination vector's current contents, the second vector and the predicate that the instruction names. One clock edge after a start strobe, the block returns the new destination contents with a valid pulse. If the encoding is not one the block accepts, it raises an illegal flag instead and returns the destination unchanged. It also returns the three register index fields it decoded, so that the caller can steer the writeback.

The whole value of a count element is used. A count is never reduced modulo the element width. Counts that reach the width saturate: arithmetic right shifts fill the element with its sign bit, and logical shifts give zero.

Top module: `pvshift_unit`

## Requirements
- R1: An instruction is legal only when bits 31:24 are 8'b00000100, bits 21:19 are 3'b010 and bits 15:13 are 3'b100. Any other pattern in these bits gives illegal_o=1 with valid_o, and result_o equal to the destination vector sampled at start.
- R2: Bits 18:16 select the operation: 000 arithmetic right, 001 logical right, 011 left, 100 reversed arithmetic right, 101 reversed logical right, 111 reversed left. The codes 010 and 110 raise illegal_o and leave the destination unchanged.
- R3: Bits 23:22 set the element size: 00 is 8 bits, 01 is 16, 10 is 32 and 11 is 64. Elements are packed little-endian, so element 0 occupies the least significant bits, and each element is shifted independently.
- R4: The count is the full unsigned value of the count element. It is never taken modulo the element width. For example, a byte left shift by 9 gives 0, not a shift by 1.
- R5: For an arithmetic right shift, a count of width−1 or more acts as a shift by width−1, so every result bit equals the sign bit.
- R6: For a logical right shift or a left shift, a count of the element width or more gives 0.
- R7: In the forward forms, the destination vector supplies the values and the second vector supplies the counts. In the reversed forms these two roles are swapped, and the result still replaces the destination.
- R8: Predication merges. An element is active when the predicate bit at its lowest byte (bit index element×width/8) is set. An inactive element keeps its original destination value.
- R9: After reset, valid_o=0, illegal_o=0 and result_o=0. valid_o rises exactly one cycle after start_i. Without start_i, valid_o is 0 and the outputs hold their values.
- R10: The outputs pg_idx_o, zm_idx_o and zdn_idx_o carry instruction bits 12:10, 9:5 and 4:0 of the started instruction. They update with valid_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe for one operation |
| insn_i | input | 32 | Instruction word |
| zdn_i | input | VLEN | Current destination vector contents |
| zm_i | input | VLEN | Second vector operand |
| pred_i | input | VLEN/8 | Governing predicate, one bit per byte |
| result_o | output | VLEN | New destination contents |
| valid_o | output | 1 | Result valid, one cycle after start |
| illegal_o | output | 1 | The started instruction was not accepted |
| pg_idx_o | output | 3 | Decoded predicate register index |
| zm_idx_o | output | 5 | Decoded second vector register index |
| zdn_idx_o | output | 5 | Decoded destination register index |

## Verification
The assertions check the following on every cycle:
- the valid pulse arrives one cycle after the start strobe;
- the illegal flag appears only together with valid;
- forbidden operation codes and malformed fixed bits are flagged;
- an all-zero predicate, or a rejected instruction, returns the destination unchanged;
- the outputs hold steady between operations.

Only the bench's scenarios can show the arithmetic itself:
- per-lane shift results across all four element sizes;
- saturation when a count reaches the width, and that counts are not wrapped modulo the width;
- the operand swap in the reversed forms;
- merging by the lowest-byte predicate bit.

These are compared with a reference model in the bench.

// File: rtl/pvshift_pkg.sv
package pvshift_pkg;

    localparam logic [7:0] MAJOR_CODE = 8'b0000_0100;
    localparam logic [2:0] GROUP_CODE = 3'b010;
    localparam logic [2:0] SUB_CODE   = 3'b100;

    typedef enum logic [1:0] {
        SH_ASR = 2'd0,
        SH_LSR = 2'd1,
        SH_LSL = 2'd2
    } shkind_e;

    typedef struct packed {
        logic       legal;
        logic       reverse;
        shkind_e    kind;
        logic [1:0] size;
        logic [2:0] pg;
        logic [4:0] zm;
        logic [4:0] zdn;
    } dec_t;

endpackage

// File: rtl/pvshift_decode.sv
module pvshift_decode
    import pvshift_pkg::*;
(
    input  logic [31:0] insn_i,
    output dec_t        dec_o
);

    logic fixed_ok;

    always_comb begin
        fixed_ok = (insn_i[31:24] == MAJOR_CODE) &&
                   (insn_i[21:19] == GROUP_CODE) &&
                   (insn_i[15:13] == SUB_CODE);

        dec_o.size    = insn_i[23:22];
        dec_o.pg      = insn_i[12:10];
        dec_o.zm      = insn_i[9:5];
        dec_o.zdn     = insn_i[4:0];
        dec_o.reverse = insn_i[18];
        dec_o.kind    = SH_ASR;
        dec_o.legal   = fixed_ok;

        unique case (insn_i[17:16])
            2'b00: dec_o.kind = SH_ASR;
            2'b01: dec_o.kind = SH_LSR;
            2'b11: dec_o.kind = SH_LSL;
            default: begin
                dec_o.kind  = SH_ASR;
                dec_o.legal = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pvshift_lane.sv
module pvshift_lane
    import pvshift_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic [W-1:0] cnt_i,
    input  shkind_e      kind_i,
    output logic [W-1:0] res_o
);

    localparam int SW = $clog2(W);
    localparam int WM1 = W - 1;
    localparam logic [W-1:0] LIM_FULL = W[W-1:0];
    localparam logic [W-1:0] LIM_SIGN = WM1[W-1:0];

    logic          over_full;
    logic          over_sign;
    logic [SW-1:0] amt;

    always_comb begin
        over_full = (cnt_i >= LIM_FULL);
        over_sign = (cnt_i >= LIM_SIGN);
        amt       = cnt_i[SW-1:0];
        res_o     = '0;
        unique case (kind_i)
            SH_ASR: begin
                if (over_sign) amt = LIM_SIGN[SW-1:0];
                res_o = $signed(val_i) >>> amt;
            end
            SH_LSR: res_o = over_full ? '0 : (val_i >> amt);
            SH_LSL: res_o = over_full ? '0 : (val_i << amt);
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/pvshift_bank.sv
module pvshift_bank
    import pvshift_pkg::*;
#(
    parameter int VLEN = 256,
    parameter int W    = 8
) (
    input  logic [VLEN-1:0]   val_i,
    input  logic [VLEN-1:0]   cnt_i,
    input  logic [VLEN-1:0]   dst_i,
    input  logic [VLEN/8-1:0] pred_i,
    input  shkind_e           kind_i,
    output logic [VLEN-1:0]   res_o
);

    localparam int NE  = VLEN / W;
    localparam int BPE = W / 8;

    for (genvar e = 0; e < NE; e++) begin : g_lane
        logic [W-1:0] shifted;

        pvshift_lane #(.W(W)) lane_i (
            .val_i  (val_i[e*W +: W]),
            .cnt_i  (cnt_i[e*W +: W]),
            .kind_i (kind_i),
            .res_o  (shifted)
        );

        assign res_o[e*W +: W] = pred_i[e*BPE] ? shifted : dst_i[e*W +: W];
    end

endmodule

// File: rtl/pvshift_unit.sv
module pvshift_unit
    import pvshift_pkg::*;
#(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       insn_i,
    input  logic [VLEN-1:0]   zdn_i,
    input  logic [VLEN-1:0]   zm_i,
    input  logic [VLEN/8-1:0] pred_i,
    output logic [VLEN-1:0]   result_o,
    output logic              valid_o,
    output logic              illegal_o,
    output logic [2:0]        pg_idx_o,
    output logic [4:0]        zm_idx_o,
    output logic [4:0]        zdn_idx_o
);

    localparam int NSIZE = 4;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [VLEN-1:0] res;
        logic [2:0]      pg;
        logic [4:0]      zm;
        logic [4:0]      zdn;
    } state_t;

    dec_t            dec;
    logic [VLEN-1:0] val_v;
    logic [VLEN-1:0] cnt_v;
    logic [VLEN-1:0] bank_res [NSIZE];
    state_t          st_d, st_q;

    pvshift_decode dec_i (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    assign val_v = dec.reverse ? zm_i  : zdn_i;
    assign cnt_v = dec.reverse ? zdn_i : zm_i;

    for (genvar k = 0; k < NSIZE; k++) begin : g_size
        pvshift_bank #(.VLEN(VLEN), .W(8 << k)) bank_i (
            .val_i  (val_v),
            .cnt_i  (cnt_v),
            .dst_i  (zdn_i),
            .pred_i (pred_i),
            .kind_i (dec.kind),
            .res_o  (bank_res[k])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = start_i;
        if (start_i) begin
            st_d.illegal = ~dec.legal;
            st_d.res     = dec.legal ? bank_res[dec.size] : zdn_i;
            st_d.pg      = dec.pg;
            st_d.zm      = dec.zm;
            st_d.zdn     = dec.zdn;
        end else begin
            st_d.illegal = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o  = st_q.res;
    assign valid_o   = st_q.valid;
    assign illegal_o = st_q.illegal;
    assign pg_idx_o  = st_q.pg;
    assign zm_idx_o  = st_q.zm;
    assign zdn_idx_o = st_q.zdn;

endmodule

// File: rtl/pvshift_checker.sv
module pvshift_checker #(
    parameter int VLEN = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [31:0]       insn_i,
    input logic [VLEN-1:0]   zdn_i,
    input logic [VLEN/8-1:0] pred_i,
    input logic [VLEN-1:0]   result_o,
    input logic              valid_o,
    input logic              illegal_o
);

    logic fixed_bad;
    logic op_bad;
    assign fixed_bad = (insn_i[31:24] != 8'h04) || (insn_i[21:19] != 3'b010) ||
                       (insn_i[15:13] != 3'b100);
    assign op_bad    = (insn_i[17:16] == 2'b10);

    assert_valid_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> valid_o);

    assert_valid_only_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !valid_o);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(result_o));

    assert_illegal_with_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> valid_o);

    assert_fixed_bits_flagged_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && fixed_bad) |=> (illegal_o && result_o == $past(zdn_i)));

    assert_bad_opcode_flagged_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_bad) |=> (illegal_o && result_o == $past(zdn_i)));

    assert_no_active_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && pred_i == '0) |=> (result_o == $past(zdn_i)));

endmodule

bind pvshift_unit pvshift_checker #(.VLEN(VLEN)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .insn_i   (insn_i),
    .zdn_i    (zdn_i),
    .pred_i   (pred_i),
    .result_o (result_o),
    .valid_o  (valid_o),
    .illegal_o(illegal_o)
);

// File: tb/pvshift_unit_tb_top.sv
module pvshift_unit_tb_top;

    localparam int VL = 256;
    localparam int PL = VL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [31:0]   insn_i = '0;
    logic [VL-1:0] zdn_i = '0;
    logic [VL-1:0] zm_i = '0;
    logic [PL-1:0] pred_i = '0;
    logic [VL-1:0] result_o;
    logic          valid_o, illegal_o;
    logic [2:0]    pg_idx_o;
    logic [4:0]    zm_idx_o, zdn_idx_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pvshift_unit #(.VLEN(VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
        .zdn_i(zdn_i), .zm_i(zm_i), .pred_i(pred_i), .result_o(result_o),
        .valid_o(valid_o), .illegal_o(illegal_o), .pg_idx_o(pg_idx_o),
        .zm_idx_o(zm_idx_o), .zdn_idx_o(zdn_idx_o)
    );

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic [2:0] op,
                                       input logic [2:0] pg, input logic [4:0] m,
                                       input logic [4:0] d);
        return {8'b0000_0100, sz, 3'b010, op, 3'b100, pg, m, d};
    endfunction

    function automatic bit is_bad(input logic [31:0] ins);
        return (ins[31:24] != 8'h04) || (ins[21:19] != 3'b010) ||
               (ins[15:13] != 3'b100) || (ins[18:16] == 3'b010) ||
               (ins[18:16] == 3'b110);
    endfunction

    function automatic logic [VL-1:0] model(input logic [31:0] ins, input logic [VL-1:0] d,
                                            input logic [VL-1:0] m, input logic [PL-1:0] p);
        int w = 8 << ins[23:22];
        logic [63:0] mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        logic [VL-1:0] out = '0;
        if (is_bad(ins)) return d;
        for (int i = 0; i < VL / w; i++) begin
            logic [63:0] de = 64'(d >> (i * w)) & mask;
            logic [63:0] me = 64'(m >> (i * w)) & mask;
            logic [63:0] v = ins[18] ? me : de;
            logic [63:0] c = ins[18] ? de : me;
            logic [63:0] r;
            logic [63:0] amt;
            case (ins[17:16])
                2'b00: begin
                    amt = (c >= 64'(w - 1)) ? 64'(w - 1) : c;
                    r = v >> amt;
                    if (v[w-1]) r = r | (mask & ~(mask >> amt));
                end
                2'b01: r = (c >= 64'(w)) ? 64'd0 : (v >> c);
                default: r = (c >= 64'(w)) ? 64'd0 : ((v << c) & mask);
            endcase
            if (!p[i * (w / 8)]) r = de;
            out = out | ({{(VL-64){1'b0}}, r & mask} << (i * w));
        end
        return out;
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [VL-1:0] act,
                       input logic [VL-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] ins, input logic [VL-1:0] d,
                       input logic [VL-1:0] m, input logic [PL-1:0] p);
        @(negedge clk);
        insn_i = ins; zdn_i = d; zm_i = m; pred_i = p; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_check(input logic [31:0] ins, input logic [VL-1:0] d,
                             input logic [VL-1:0] m, input logic [PL-1:0] p,
                             input string req);
        logic [VL-1:0] exp;
        exp = model(ins, d, m, p);
        run(ins, d, m, p);
        chk(valid_o && (illegal_o == is_bad(ins)) && result_o == exp, req, result_o, exp);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        report();
    end

    initial begin
        logic [VL-1:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(!valid_o && !illegal_o && result_o == '0, "R9 reset", result_o, '0);
        rst_n = 1'b1;

        // R4: byte left shift by 9 is zero, not a shift by 1
        run(mk(2'b00, 3'b011, 3'd0, 5'd1, 5'd2), {32{8'h81}}, {32{8'h09}}, '1);
        chk(result_o == '0, "R4 no modulo", result_o, '0);

        // R5: ASR saturates to sign fill
        run(mk(2'b00, 3'b000, 3'd0, 5'd1, 5'd2), {16{8'h7F, 8'h80}}, {32{8'd200}}, '1);
        chk(result_o == {16{8'h00, 8'hFF}}, "R5 asr clamp", result_o, {16{8'h00, 8'hFF}});

        // R9: valid pulse lasts one cycle, result held
        held = result_o;
        @(negedge clk);
        chk(!valid_o && result_o == held, "R9 hold", result_o, held);

        // R6: halfword LSR by 16 gives 0, by 15 gives 1
        run(mk(2'b01, 3'b001, 3'd0, 5'd1, 5'd2), {8{16'h8000, 16'h8000}},
            {8{16'd15, 16'd16}}, '1);
        chk(result_o == {8{16'h0001, 16'h0000}}, "R6 lsr range", result_o,
            {8{16'h0001, 16'h0000}});

        // R7: reversed left shift takes counts from the destination
        run(mk(2'b10, 3'b111, 3'd0, 5'd1, 5'd2), {8{32'd4}}, {8{32'h0000_0011}}, '1);
        chk(result_o == {8{32'h0000_0110}}, "R7 reversed", result_o, {8{32'h0000_0110}});

        // R8: word lanes active only via lowest-byte predicate bit
        run(mk(2'b10, 3'b011, 3'd0, 5'd1, 5'd2), {8{32'h1}}, {8{32'd1}},
            32'b1110_0001_1110_0001_1110_0001_1110_0001);
        chk(result_o == {4{32'h1, 32'h2}}, "R8 merge", result_o, {4{32'h1, 32'h2}});

        // R1: malformed fixed bits
        begin
            logic [31:0] bad = mk(2'b00, 3'b000, 3'd0, 5'd1, 5'd2) ^ 32'h0000_8000;
            logic [VL-1:0] d = rnd_vec();
            run(bad, d, rnd_vec(), '1);
            chk(valid_o && illegal_o && result_o == d, "R1 fixed bits", result_o, d);
        end

        // R2: forbidden op codes
        run_check(mk(2'b11, 3'b010, 3'd1, 5'd3, 5'd4), rnd_vec(), rnd_vec(), '1, "R2 op010");
        run_check(mk(2'b01, 3'b110, 3'd1, 5'd3, 5'd4), rnd_vec(), rnd_vec(), '1, "R2 op110");

        // R10: decoded index fields
        run(mk(2'b00, 3'b001, 3'd5, 5'd19, 5'd27), '0, '0, '0);
        chk(pg_idx_o == 3'd5 && zm_idx_o == 5'd19 && zdn_idx_o == 5'd27, "R10 fields",
            {pg_idx_o, zm_idx_o, zdn_idx_o}, {3'd5, 5'd19, 5'd27});

        // R3 R4 R5 R6 R7 R8: random mix over all sizes and forms
        for (int t = 0; t < 300; t++) begin
            logic [2:0] ops [6] = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b101, 3'b111};
            logic [VL-1:0] cv = rnd_vec();
            logic [1:0] sz = 2'($urandom_range(0, 3));
            if (t % 2 == 0) begin
                for (int b = 0; b < VL / 8; b++)
                    cv[b*8 +: 8] = 8'($urandom_range(0, 72));
                for (int e = 0; e < VL / (8 << sz); e++)
                    for (int b = 1; b < (1 << sz); b++)
                        cv[e*(8 << sz) + b*8 +: 8] = (t % 4 == 0) ? 8'h00 : cv[e*(8 << sz) + b*8 +: 8];
            end
            run_check(mk(sz, ops[$urandom_range(0, 5)], 3'($urandom), 5'($urandom), 5'($urandom)),
                      (t % 3 == 0) ? cv : rnd_vec(), (t % 3 == 0) ? rnd_vec() : cv,
                      PL'({$urandom, $urandom}), "R3 random");
        end

        report();
    end

endmodule